// File: doc/BRIEF.md
# Self-Correcting Decade Johnson Counter

This block counts qualified edges on two slow control inputs and presents the count as ten one-hot decoded lines plus an active-low carry. Internally it is a five-stage twisted-ring (Johnson) register, so it walks through ten legal codes. Only one stage changes per step, and each decoded line depends on just two adjacent stages. One count input acts on its rising edge while the other input is low. The other acts on its falling edge while the first input is high. Both inputs are brought into a single fast system clock domain and edge-detected there, so the whole block is synchronous.

A master-reset input clears the count as soon as it rises, with no clock needed. Its release is retimed so the register leaves reset cleanly. The carry line is low for the upper half of the decade, so it can feed the rising-edge count input of a following stage to build a chain of decades. If the register ever holds one of the 22 codes outside the legal ring, the next-state logic brings it back onto the ring at the next count. A load port lets a test place any 5-bit code in the register.

Top module: `decade_johnson_counter`

## Requirements
- R1: Each qualified advance moves the count from state k to state (k+1) mod 10. The legal register codes, written MSB first, are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000 and 10000 for states 0 to 9.
- R2: A rising edge on `rise_in` while `fall_in` is low advances the count by one. The new state appears three system-clock edges after the input change.
- R3: A falling edge on `fall_in` while `rise_in` is high advances the count. No other input change advances it: a rising edge of `rise_in` while `fall_in` is high, a falling edge of `fall_in` while `rise_in` is low, a rising edge of `fall_in`, or a falling edge of `rise_in`. A single change that meets both conditions advances the count only once.
- R4: `dec_out` is one-hot in every legal state, with bit k high in state k.
- R5: `carry_n` is low in states 5 to 9 and high in states 0 to 4.
- R6: While `mr` is high the count is 0 at once (`dec_out` = 0000000001, `carry_n` = 1), whatever the count inputs do. It stays 0 for two system-clock edges after `mr` falls.
- R7: `rst_n` low at a rising system-clock edge forces state 0.
- R8: `tst_load` high at a clock edge writes `tst_code` into the register, and this takes priority over an advance. From any illegal code the register is back in the legal ring within 11 advances (this design needs one), and it then cycles through all ten states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr | input | 1 | Master reset: asserted asynchronously, released synchronously |
| rise_in | input | 1 | Count input acting on its rising edge |
| fall_in | input | 1 | Count input acting on its falling edge |
| tst_load | input | 1 | Test hook: load `tst_code` into the register |
| tst_code | input | 5 | Test hook: raw register code to load |
| dec_out | output | 10 | One-hot decoded count |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The assertions assume that `rise_in` and `fall_in` are low while `rst_n` is low. A count input already high at reset release would look like a fresh edge. They also assume that the count inputs are slow next to the system clock, so that at most one level change per input reaches the synchronizers in any three-cycle window. The stimulus follows these rules. It changes the count inputs only on falling clock edges and holds each level for five system cycles. It keeps both inputs low across every reset. It also moves `mr` only while the inputs are idle, so no edge is lost in a partly released reset.

// File: rtl/dcnt_pkg.sv
// Package dcnt_pkg
// Shared helpers for the decade Johnson counter.
// Assumes: register widths up to 32 stages.
package dcnt_pkg;

    // A Johnson code is legal when its bits change value at most once
    // between neighbouring stages (one block of ones, anchored at an end).
    function automatic logic ring_legal(input logic [31:0] code, input int unsigned width);
        int unsigned changes;
        changes = 0;
        for (int unsigned i = 0; i + 1 < width; i++) begin
            if (code[i] != code[i+1]) changes++;
        end
        return (changes <= 1);
    endfunction

endpackage

// File: rtl/dcnt_reset_ctl.sv
// Module dcnt_reset_ctl
// Turns the asynchronous master reset into a hold signal that rises at once
// with mr and falls only after RLS_STAGES clean clock edges.
// Assumes: RLS_STAGES >= 2.
module dcnt_reset_ctl #(
    parameter int unsigned RLS_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr,
    output logic hold
);

    logic [RLS_STAGES-1:0] rls_q;

    // Release shifter: set asynchronously by mr, drained by zeros afterwards.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            rls_q <= '1;
        end else if (!rst_n) begin
            rls_q <= '0;
        end else begin
            rls_q <= {rls_q[RLS_STAGES-2:0], 1'b0};
        end
    end

    assign hold = rls_q[RLS_STAGES-1];

    // R6
    release_drain_chk: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (!hold && !$past(hold)) |=> !hold);

endmodule

// File: rtl/dcnt_edge_qual.sv
// Module dcnt_edge_qual
// Synchronizes both count inputs to clk, detects their edges against the
// previous synchronized value and produces a single-cycle advance pulse.
// Assumes: inputs are slow compared to clk and low during reset.
module dcnt_edge_qual #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_in,
    input  logic fall_in,
    output logic adv
);

    logic [SYNC_STAGES-1:0] rise_sync_q;
    logic [SYNC_STAGES-1:0] fall_sync_q;
    logic                   rise_prev_q;
    logic                   fall_prev_q;
    logic                   rise_now;
    logic                   fall_now;
    logic                   rise_hit;
    logic                   fall_hit;

    // Synchronizer chains plus one history flop per input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sync_q <= '0;
            fall_sync_q <= '0;
            rise_prev_q <= 1'b0;
            fall_prev_q <= 1'b0;
        end else begin
            rise_sync_q <= {rise_sync_q[SYNC_STAGES-2:0], rise_in};
            fall_sync_q <= {fall_sync_q[SYNC_STAGES-2:0], fall_in};
            rise_prev_q <= rise_sync_q[SYNC_STAGES-1];
            fall_prev_q <= fall_sync_q[SYNC_STAGES-1];
        end
    end

    // Edge qualification: each edge counts only with the other input at its enabling level.
    always_comb begin
        rise_now = rise_sync_q[SYNC_STAGES-1];
        fall_now = fall_sync_q[SYNC_STAGES-1];
        rise_hit = rise_now && !rise_prev_q && !fall_now;
        fall_hit = !fall_now && fall_prev_q && rise_now;
        adv      = rise_hit || fall_hit;
    end

    // R3
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv);

    // R2
    adv_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> ((rise_now != rise_prev_q) || (fall_now != fall_prev_q)));

endmodule

// File: rtl/dcnt_johnson_core.sv
// Module dcnt_johnson_core
// Twisted-ring state register with code correction and a test load path.
// An illegal code is steered back to state 0 or 1 on the next advance by
// clearing all stages above the first; legal codes shift normally.
// Assumes: hold is driven by dcnt_reset_ctl from the same mr.
module dcnt_johnson_core
    import dcnt_pkg::*;
#(
    parameter int unsigned STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr,
    input  logic              hold,
    input  logic              adv,
    input  logic              load,
    input  logic [STAGES-1:0] load_code,
    output logic [STAGES-1:0] state
);

    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] state_nx;
    logic              legal;

    // Next-state: twisted shift when legal, collapse upper stages when not.
    always_comb begin
        legal = ring_legal(32'(state_q), STAGES);
        if (legal) begin
            state_nx = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
        end else begin
            state_nx = {{(STAGES-1){1'b0}}, ~state_q[STAGES-1]};
        end
    end

    // State register: mr clears asynchronously, then reset, hold, load, advance.
    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            state_q <= '0;
        end else if (!rst_n) begin
            state_q <= '0;
        end else if (hold) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= load_code;
        end else if (adv) begin
            state_q <= state_nx;
        end
    end

    assign state = state_q;

    // R1
    legal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (legal && !load) |=> ring_legal(32'(state_q), STAGES));

    // R1
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (legal && adv && !load && !hold) |=> (state_q != $past(state_q)));

    // R8
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n || mr)
        (!legal && adv && !load && !hold) |=> ring_legal(32'(state_q), STAGES));

    // R6
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || mr)
        hold |=> (state_q == '0));

endmodule

// File: rtl/dcnt_decoder.sv
// Module dcnt_decoder
// Decodes the Johnson register into one-hot lines, each from one pair of
// adjacent stages (or the two end stages), so that a legal step cannot glitch.
// Assumes: STAGES >= 2.
module dcnt_decoder #(
    parameter int unsigned STAGES = 5,
    localparam int unsigned STATES = 2 * STAGES
) (
    input  logic [STAGES-1:0] state,
    output logic [STATES-1:0] dec,
    output logic              carry_n
);

    // Lower half: ones filling up from stage 0.
    for (genvar k = 0; k < STAGES; k++) begin : g_lo
        if (k == 0) begin : g_zero
            assign dec[k] = ~state[STAGES-1] & ~state[0];
        end else begin : g_fill
            assign dec[k] = state[k-1] & ~state[k];
        end
    end

    // Upper half: zeros filling up from stage 0.
    for (genvar k = STAGES; k < STATES; k++) begin : g_hi
        if (k == STAGES) begin : g_full
            assign dec[k] = state[STAGES-1] & state[0];
        end else begin : g_drain
            assign dec[k] = ~state[k-STAGES-1] & state[k-STAGES];
        end
    end

    // Carry is the inverted last stage: low for the upper half of the decade.
    assign carry_n = ~state[STAGES-1];

endmodule

// File: rtl/decade_johnson_counter.sv
// Module decade_johnson_counter
// Top of the self-correcting decade counter: input edge qualification,
// master-reset release, state register and glitch-free decode.
// Assumes: count inputs are slow compared to clk; tst_load is a test-only hook.
module decade_johnson_counter
    import dcnt_pkg::*;
#(
    parameter int unsigned STAGES      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned STATES     = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr,
    input  logic              rise_in,
    input  logic              fall_in,
    input  logic              tst_load,
    input  logic [STAGES-1:0] tst_code,
    output logic [STATES-1:0] dec_out,
    output logic              carry_n
);

    logic              adv;
    logic              hold;
    logic [STAGES-1:0] state;

    dcnt_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_in (rise_in),
        .fall_in (fall_in),
        .adv     (adv)
    );

    dcnt_reset_ctl #(.RLS_STAGES(2)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .mr    (mr),
        .hold  (hold)
    );

    dcnt_johnson_core #(.STAGES(STAGES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr        (mr),
        .hold      (hold),
        .adv       (adv),
        .load      (tst_load),
        .load_code (tst_code),
        .state     (state)
    );

    dcnt_decoder #(.STAGES(STAGES)) u_dec (
        .state   (state),
        .dec     (dec_out),
        .carry_n (carry_n)
    );

    // R4
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_legal(32'(state), STAGES) |-> $onehot(dec_out));

    // R5
    carry_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_legal(32'(state), STAGES) |-> (carry_n == (dec_out[STATES-1:STAGES] == '0)));

    // R6
    mr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr |-> (dec_out[0] && carry_n));

endmodule

// File: tb/test_decade_johnson_counter.sv
module test_decade_johnson_counter;

    localparam int NST = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic       rise_in = 1'b0;
    logic       fall_in = 1'b0;
    logic       tst_load = 1'b0;
    logic [4:0] tst_code = '0;
    logic [9:0] dec_out;
    logic       carry_n;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_st = 0;
    bit done = 0;

    // {rise level, fall level, advance expected}, walked from rise=0, fall=0
    localparam logic [2:0] VEC [10] = '{
        3'b101, 3'b000, 3'b010, 3'b110, 3'b101,
        3'b110, 3'b010, 3'b000, 3'b101, 3'b000
    };

    decade_johnson_counter i_decade_johnson_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr       (mr),
        .rise_in  (rise_in),
        .fall_in  (fall_in),
        .tst_load (tst_load),
        .tst_code (tst_code),
        .dec_out  (dec_out),
        .carry_n  (carry_n)
    );

    always #5 clk = ~clk;

    task automatic check_state(input string req, input int e);
        logic [9:0] ed;
        logic       ec;
        ed = 10'd1 << e;
        ec = (e < 5);
        n_cmp++;
        if (dec_out !== ed || carry_n !== ec) begin
            n_bad++;
            $display("FAIL %s: dec_out=%b carry_n=%b expected dec_out=%b carry_n=%b",
                     req, dec_out, carry_n, ed, ec);
        end
    endtask

    task automatic apply(input logic r, input logic f);
        @(negedge clk);
        rise_in = r;
        fall_in = f;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse();
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
    endtask

    function automatic bit code_legal(input logic [4:0] c);
        return c inside {5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                         5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};
    endfunction

    function automatic int onehot_idx(input logic [9:0] d);
        int idx;
        idx = -1;
        for (int i = 0; i < NST; i++) if (d[i]) idx = i;
        return idx;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R7 reset state", 0);

        // R2 R3: table of input level pairs, two passes
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 10; v++) begin
                apply(VEC[v][2], VEC[v][1]);
                if (VEC[v][0]) exp_st = (exp_st + 1) % NST;
                check_state(VEC[v][0] ? "R2/R3 qualified edge" : "R3 unqualified change", exp_st);
            end
        end

        // R3: one change satisfying both conditions advances once
        apply(1'b0, 1'b1);
        check_state("R3 fall high idle", exp_st);
        apply(1'b1, 1'b0);
        exp_st = (exp_st + 1) % NST;
        check_state("R3 double condition single advance", exp_st);
        apply(1'b0, 1'b0);

        // R1 R4 R5: full decade plus wrap
        for (int i = 0; i < 12; i++) begin
            pulse();
            exp_st = (exp_st + 1) % NST;
            check_state("R1 R4 R5 step", exp_st);
        end

        // R7: synchronous reset from a nonzero state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_state("R7 sync reset", 0);
        rst_n = 1'b1;
        exp_st = 0;
        pulse();
        pulse();
        exp_st = 2;
        check_state("R2 count after reset", exp_st);

        // R6: asynchronous master reset, immune to count edges
        @(negedge clk);
        #2 mr = 1'b1;
        #1 check_state("R6 immediate clear", 0);
        pulse();
        check_state("R6 edges ignored under mr", 0);
        @(negedge clk);
        mr = 1'b0;
        @(negedge clk);
        check_state("R6 held after release", 0);
        repeat (2) @(negedge clk);
        pulse();
        check_state("R6 counts after release", 1);

        // R8: load a legal code (state 3 = 00111)
        @(negedge clk);
        tst_load = 1'b1;
        tst_code = 5'b00111;
        @(negedge clk);
        tst_load = 1'b0;
        check_state("R8 load legal code", 3);

        // R8: every illegal code recovers within 11 advances and then cycles
        for (int c = 0; c < 32; c++) begin
            if (!code_legal(5'(c))) begin
                int n;
                int idx;
                bit cyc_ok;
                @(negedge clk);
                tst_load = 1'b1;
                tst_code = 5'(c);
                @(negedge clk);
                tst_load = 1'b0;
                n = 0;
                do begin
                    pulse();
                    n++;
                end while (!$onehot(dec_out) && n < 11);
                n_cmp++;
                if (!$onehot(dec_out)) begin
                    n_bad++;
                    $display("FAIL R8 code %b: dec_out=%b after %0d advances expected one-hot within 11",
                             5'(c), dec_out, n);
                end
                idx = onehot_idx(dec_out);
                cyc_ok = 1;
                for (int s = 1; s <= NST; s++) begin
                    pulse();
                    if (dec_out !== (10'd1 << ((idx + s) % NST)) ||
                        carry_n !== (((idx + s) % NST) < 5))
                        cyc_ok = 0;
                end
                n_cmp++;
                if (!cyc_ok) begin
                    n_bad++;
                    $display("FAIL R8 code %b: cycle after recovery ends dec_out=%b carry_n=%b expected dec_out=%b",
                             5'(c), dec_out, carry_n, 10'd1 << idx);
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule